// File: doc/BRIEF.md
# Prefixed Register-Add Decoder

This block accepts instruction bytes one at a time, with a byte taken on each clock in which `byte_valid` is high. It decodes a reduced register-to-register add. An instruction may begin with prefix bytes: an operand-size override (0x66) and a register-extension byte (0x40 to 0x4F). Next comes an opcode, 0x00 for an 8-bit add or 0x01 for a full-width add. The last byte is a register-direct operand byte, whose top two bits are 11. One clock after the operand byte is taken, the block raises `done` for one cycle. In that cycle it shows the operand width, the source and destination register numbers, a legacy high-byte flag for each operand, and the instruction length in bytes.

An 8-bit register code is read in one of two ways. With no extension byte, codes 4 to 7 name the second byte of registers 0 to 3. With an extension byte, the same codes name the low byte of registers 4 to 7. Bits of the extension byte also select 64-bit width and add a fourth bit to each register number. An extension byte only takes effect when it sits directly before the opcode. A byte that does not fit the grammar raises `err` for one cycle and sends the decoder back to its idle state. The reset input clears at once and is released on the clock.

Top module: `regop_decoder`

## Requirements
- R1: After reset, `done` and `err` are 0. Reset also discards any prefix already taken, so an instruction that follows decodes as if no prefix had been seen.
- R2: Opcode 0x01 with no prefix decodes as width code 2 (32-bit) with length 2. `done` rises in the cycle after the operand byte is taken, and the output fields are valid in that cycle.
- R3: A 0x66 byte before opcode 0x01 gives width code 1 (16-bit), and the length counts the prefix (3 for one prefix).
- R4: An extension byte with bit 3 set, placed before opcode 0x01, gives width code 3 (64-bit). This holds even when 0x66 also comes before it.
- R5: Opcode 0x00 with no extension byte gives width code 0 (8-bit). Codes 0 to 3 map to registers 0 to 3 with the high-byte flag 0. Codes 4 to 7 raise the high-byte flag and report register number code minus 4.
- R6: Opcode 0x00 with an extension byte (0x40 to 0x4F) maps codes 4 to 7 to registers 4 to 7 with the high-byte flag 0. Bit 3 of the extension byte does not change the 8-bit width.
- R7: The source register comes from operand bits 5:3 and the destination from bits 2:0. Extension bit 2 becomes bit 3 of the source number, and extension bit 0 becomes bit 3 of the destination number.
- R8: An extension byte followed by a 0x66 byte has no effect: its register bits and width bit are dropped. The length still counts both prefix bytes.
- R9: An operand byte whose bits 7:6 are not 11 gives a one-cycle `err` with no `done`. The next instruction then decodes normally.
- R10: A byte that is neither a prefix nor opcode 0x00 or 0x01, received where an opcode or prefix is expected, gives a one-cycle `err` and returns the decoder to idle.
- R11: A prefix byte that would exceed MAX_PFX prefixes gives `err`.
- R12: Cycles with `byte_valid` low are ignored at any point inside an instruction.
- R13: The decoded output fields keep their values between `done` pulses, including while a later instruction is only partly received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted at once, released on the clock |
| byte_valid | input | 1 | `byte_in` holds an instruction byte this cycle |
| byte_in | input | 8 | Instruction byte |
| done | output | 1 | One-cycle pulse: the decoded fields are valid |
| err | output | 1 | One-cycle pulse: an unsupported byte was received |
| op_size | output | 2 | Width code: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| src_reg | output | 4 | Source register number |
| src_hi8 | output | 1 | Source is the second byte of register `src_reg` |
| dst_reg | output | 4 | Destination register number |
| dst_hi8 | output | 1 | Destination is the second byte of register `dst_reg` |
| inst_len | output | $clog2(MAX_PFX+3) | Instruction length in bytes |

## Verification
The bench uses the default MAX_PFX of 2. With that value, two prefix bytes can come before an opcode, which allows four-byte instructions. These include a 0x66 byte together with a 64-bit extension byte, and an extension byte that a following 0x66 cancels. A third prefix byte trips the prefix limit, so the overflow error can be reached in three bytes. The bench also sweeps all eight 8-bit register codes, both with and without an extension byte, so that both readings of codes 4 to 7 are seen side by side.

// File: rtl/regop_pkg.sv
package regop_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PFX  = 2'd1,
    ST_OPND = 2'd2
  } seq_state_t;

  typedef enum logic [1:0] {
    SZ8  = 2'd0,
    SZ16 = 2'd1,
    SZ32 = 2'd2,
    SZ64 = 2'd3
  } opsize_t;

  // captured extension byte: only the bits the decoder uses
  typedef struct packed {
    logic present;
    logic w64;
    logic src_x;
    logic dst_x;
  } ext_t;

  localparam logic [7:0] BYTE_OSZ  = 8'h66;
  localparam logic [3:0] EXT_NIB   = 4'h4;
  localparam logic [6:0] OPC_ADD_U = 7'h00;   // 0x00 / 0x01
  localparam logic [1:0] MOD_REG   = 2'b11;
  localparam int         CODE_W    = 3;
  localparam int         REG_W     = CODE_W + 1;

endpackage

// File: rtl/regop_rstsync.sv
module regop_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/regop_fsm.sv
module regop_fsm
  import regop_pkg::*;
#(
  parameter  int MAX_PFX = 2,
  localparam int CNT_W   = $clog2(MAX_PFX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_valid,
  input  logic [7:0]       byte_in,
  output logic             fire,
  output logic             fault,
  output ext_t             ext_o,
  output logic             osz_o,
  output logic             wide_o,
  output logic [CNT_W-1:0] cnt_o
);

  seq_state_t       state_q, state_d;
  ext_t             ext_q, ext_d;
  logic             osz_q, osz_d;
  logic             wide_q, wide_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  logic is_ext, is_osz, is_opc, pfx_full;

  assign is_ext   = (byte_in[7:4] == EXT_NIB);
  assign is_osz   = (byte_in == BYTE_OSZ);
  assign is_opc   = (byte_in[7:1] == OPC_ADD_U);
  assign pfx_full = (cnt_q == CNT_W'(MAX_PFX));

  // next-state process
  always_comb begin
    state_d = state_q;
    ext_d   = ext_q;
    osz_d   = osz_q;
    wide_d  = wide_q;
    cnt_d   = cnt_q;
    fire    = 1'b0;
    fault   = 1'b0;

    if (byte_valid) begin
      unique case (state_q)
        ST_IDLE, ST_PFX: begin
          if (is_ext || is_osz) begin
            if (pfx_full) begin
              fault   = 1'b1;
              state_d = ST_IDLE;
              ext_d   = '0;
              osz_d   = 1'b0;
              wide_d  = 1'b0;
              cnt_d   = '0;
            end else begin
              state_d = ST_PFX;
              cnt_d   = cnt_q + CNT_W'(1);
              if (is_ext) begin
                ext_d = '{present: 1'b1, w64: byte_in[3],
                          src_x: byte_in[2], dst_x: byte_in[0]};
              end else begin
                osz_d = 1'b1;
                ext_d = '0;   // extension no longer adjacent to the opcode
              end
            end
          end else if (is_opc) begin
            state_d = ST_OPND;
            wide_d  = byte_in[0];
          end else begin
            fault   = 1'b1;
            state_d = ST_IDLE;
            ext_d   = '0;
            osz_d   = 1'b0;
            wide_d  = 1'b0;
            cnt_d   = '0;
          end
        end
        ST_OPND: begin
          if (byte_in[7:6] == MOD_REG) fire  = 1'b1;
          else                         fault = 1'b1;
          state_d = ST_IDLE;
          ext_d   = '0;
          osz_d   = 1'b0;
          wide_d  = 1'b0;
          cnt_d   = '0;
        end
        default: begin
          state_d = ST_IDLE;
          ext_d   = '0;
          osz_d   = 1'b0;
          wide_d  = 1'b0;
          cnt_d   = '0;
        end
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ext_q   <= '0;
      osz_q   <= 1'b0;
      wide_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (byte_valid) begin
      state_q <= state_d;
      ext_q   <= ext_d;
      osz_q   <= osz_d;
      wide_q  <= wide_d;
      cnt_q   <= cnt_d;
    end
  end

  assign ext_o  = ext_q;
  assign osz_o  = osz_q;
  assign wide_o = wide_q;
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/regop_regmap.sv
module regop_regmap
  import regop_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              ext_bit,
  input  logic              ext_present,
  input  logic              byte_op,
  output logic [REG_W-1:0]  reg_num,
  output logic              hi8
);

  always_comb begin
    hi8 = byte_op && !ext_present && code[CODE_W-1];
    if (hi8) reg_num = {{(REG_W-CODE_W+1){1'b0}}, code[CODE_W-2:0]};
    else     reg_num = {ext_bit, code};
  end

endmodule

// File: rtl/regop_decoder.sv
module regop_decoder
  import regop_pkg::*;
#(
  parameter  int MAX_PFX = 2,
  localparam int CNT_W   = $clog2(MAX_PFX + 1),
  localparam int LEN_W   = $clog2(MAX_PFX + 3)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_valid,
  input  logic [7:0]       byte_in,
  output logic             done,
  output logic             err,
  output logic [1:0]       op_size,
  output logic [3:0]       src_reg,
  output logic             src_hi8,
  output logic [3:0]       dst_reg,
  output logic             dst_hi8,
  output logic [LEN_W-1:0] inst_len
);

  localparam int NOPS = 2;   // 0: source, 1: destination

  logic             rst_core_n;
  logic             fire, fault;
  ext_t             ext;
  logic             osz, wide;
  logic [CNT_W-1:0] cnt;

  logic [CODE_W-1:0] op_code [NOPS];
  logic              op_ext  [NOPS];
  logic [REG_W-1:0]  op_reg  [NOPS];
  logic              op_hi   [NOPS];

  opsize_t          size_d, size_q;
  logic [LEN_W-1:0] len_d, len_q;
  logic [REG_W-1:0] src_q, dst_q;
  logic             src_hi_q, dst_hi_q;
  logic             done_q, err_q;

  regop_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_core_n)
  );

  regop_fsm #(.MAX_PFX(MAX_PFX)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .byte_valid (byte_valid),
    .byte_in    (byte_in),
    .fire       (fire),
    .fault      (fault),
    .ext_o      (ext),
    .osz_o      (osz),
    .wide_o     (wide),
    .cnt_o      (cnt)
  );

  assign op_code[0] = byte_in[5:3];
  assign op_code[1] = byte_in[2:0];
  assign op_ext[0]  = ext.src_x;
  assign op_ext[1]  = ext.dst_x;

  for (genvar i = 0; i < NOPS; i++) begin : g_opnd
    regop_regmap u_map (
      .code        (op_code[i]),
      .ext_bit     (op_ext[i]),
      .ext_present (ext.present),
      .byte_op     (!wide),
      .reg_num     (op_reg[i]),
      .hi8         (op_hi[i])
    );
  end

  always_comb begin
    if (!wide)                     size_d = SZ8;
    else if (ext.present && ext.w64) size_d = SZ64;
    else if (osz)                  size_d = SZ16;
    else                           size_d = SZ32;
    len_d = LEN_W'(cnt) + LEN_W'(2);
  end

  // pulse registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= fire;
      err_q  <= fault;
    end
  end

  // result registers, enabled by a completed decode
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      size_q   <= SZ8;
      len_q    <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      src_hi_q <= 1'b0;
      dst_hi_q <= 1'b0;
    end else if (fire) begin
      size_q   <= size_d;
      len_q    <= len_d;
      src_q    <= op_reg[0];
      dst_q    <= op_reg[1];
      src_hi_q <= op_hi[0];
      dst_hi_q <= op_hi[1];
    end
  end

  assign done     = done_q;
  assign err      = err_q;
  assign op_size  = size_q;
  assign inst_len = len_q;
  assign src_reg  = src_q;
  assign dst_reg  = dst_q;
  assign src_hi8  = src_hi_q;
  assign dst_hi8  = dst_hi_q;

endmodule

// File: rtl/regop_decoder_chk.sv
module regop_decoder_chk #(
  parameter  int MAX_PFX = 2,
  localparam int LEN_W   = $clog2(MAX_PFX + 3)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_valid,
  input logic [7:0]       byte_in,
  input logic             done,
  input logic             err,
  input logic [1:0]       op_size,
  input logic [3:0]       src_reg,
  input logic             src_hi8,
  input logic [3:0]       dst_reg,
  input logic             dst_hi8,
  input logic [LEN_W-1:0] inst_len
);

  // R2
  done_after_opnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(byte_valid) && $past(byte_in[7:6]) == 2'b11));

  // R9
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R5
  hi8_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (src_hi8 || dst_hi8)) |-> (op_size == 2'd0 &&
      (!src_hi8 || src_reg[3:2] == 2'b00) && (!dst_hi8 || dst_reg[3:2] == 2'b00)));

  // R11
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (inst_len >= LEN_W'(2) && inst_len <= LEN_W'(MAX_PFX + 2)));

  // R13
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(op_size) && $stable(src_reg) && $stable(dst_reg) &&
               $stable(src_hi8) && $stable(dst_hi8) && $stable(inst_len)));

endmodule

bind regop_decoder regop_decoder_chk #(.MAX_PFX(MAX_PFX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .byte_valid (byte_valid),
  .byte_in    (byte_in),
  .done       (done),
  .err        (err),
  .op_size    (op_size),
  .src_reg    (src_reg),
  .src_hi8    (src_hi8),
  .dst_reg    (dst_reg),
  .dst_hi8    (dst_hi8),
  .inst_len   (inst_len)
);

// File: tb/regop_decoder_test.sv
`timescale 1ns/1ps
module regop_decoder_test;

  localparam int MAX_PFX = 2;
  localparam int LEN_W   = $clog2(MAX_PFX + 3);

  logic             clk;
  logic             rst_n;
  logic             byte_valid;
  logic [7:0]       byte_in;
  logic             done, err;
  logic [1:0]       op_size;
  logic [3:0]       src_reg, dst_reg;
  logic             src_hi8, dst_hi8;
  logic [LEN_W-1:0] inst_len;

  int total = 0;
  int bad   = 0;
  bit fin   = 0;

  regop_decoder #(.MAX_PFX(MAX_PFX)) uut (
    .clk (clk), .rst_n (rst_n), .byte_valid (byte_valid), .byte_in (byte_in),
    .done (done), .err (err), .op_size (op_size), .src_reg (src_reg),
    .src_hi8 (src_hi8), .dst_reg (dst_reg), .dst_hi8 (dst_hi8), .inst_len (inst_len)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic put(input logic [7:0] b);
    byte_valid = 1'b1;
    byte_in    = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic gap(input int n);
    byte_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // compare the whole output word at the current negedge
  task automatic check_dec(input string tag, input logic dn, input logic er,
                           input logic [1:0] sz, input logic [3:0] sr, input logic sh,
                           input logic [3:0] dr, input logic dh, input logic [LEN_W-1:0] ln);
    logic [15+LEN_W:0] act, exp;
    act = {done, err, op_size, src_reg, src_hi8, dst_reg, dst_hi8, inst_len};
    exp = {dn, er, sz, sr, sh, dr, dh, ln};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_err(input string tag);
    total++;
    if ({done, err} !== 2'b01) begin
      bad++;
      $display("FAIL %s actual done/err=%b expected=01", tag, {done, err});
    end
  endtask

  task automatic do_reset();
    byte_valid = 1'b0;
    byte_in    = 8'h00;
    rst_n      = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    total++;
    if ({done, err} !== 2'b00) begin
      bad++;
      $display("FAIL R1 reset pulses actual=%b expected=00", {done, err});
    end
    put(8'h48);
    do_reset();
    put(8'h00); put(8'hC5);
    check_dec("R1 stale prefix dropped", 1, 0, 2'd0, 4'd0, 0, 4'd1, 1, 3'd2);
  endtask

  task automatic t_plain32();
    put(8'h01); put(8'hC1);
    check_dec("R2 add32", 1, 0, 2'd2, 4'd0, 0, 4'd1, 0, 3'd2);
    put(8'h01); put(8'hD8);
    check_dec("R2 R7 src field", 1, 0, 2'd2, 4'd3, 0, 4'd0, 0, 3'd2);
  endtask

  task automatic t_size16();
    put(8'h66); put(8'h01); put(8'hC2);
    check_dec("R3 add16", 1, 0, 2'd1, 4'd0, 0, 4'd2, 0, 3'd3);
  endtask

  task automatic t_size64();
    put(8'h48); put(8'h01); put(8'hC7);
    check_dec("R4 add64", 1, 0, 2'd3, 4'd0, 0, 4'd7, 0, 3'd3);
    put(8'h66); put(8'h48); put(8'h01); put(8'hC3);
    check_dec("R4 w over osz", 1, 0, 2'd3, 4'd0, 0, 4'd3, 0, 3'd4);
  endtask

  task automatic t_byte_legacy();
    for (int c = 0; c < 8; c++) begin
      put(8'h00); put(8'hC0 | 8'(c));
      check_dec("R5 legacy byte code", 1, 0, 2'd0, 4'd0, 0,
                (c < 4) ? 4'(c) : 4'(c - 4), (c >= 4), 3'd2);
    end
    put(8'h00); put(8'hE0);
    check_dec("R5 high-byte source", 1, 0, 2'd0, 4'd0, 1, 4'd0, 0, 3'd2);
  endtask

  task automatic t_byte_ext();
    for (int c = 4; c < 8; c++) begin
      put(8'h40); put(8'h00); put(8'hC0 | 8'(c));
      check_dec("R6 ext byte code", 1, 0, 2'd0, 4'd0, 0, 4'(c), 0, 3'd3);
    end
    put(8'h48); put(8'h00); put(8'hC5);
    check_dec("R6 w ignored on byte op", 1, 0, 2'd0, 4'd0, 0, 4'd5, 0, 3'd3);
  endtask

  task automatic t_ext_bits();
    put(8'h45); put(8'h01); put(8'hC8);
    check_dec("R7 ext reg bits", 1, 0, 2'd2, 4'd9, 0, 4'd8, 0, 3'd3);
    put(8'h4F); put(8'h01); put(8'hFF);
    check_dec("R7 all ext bits", 1, 0, 2'd3, 4'd15, 0, 4'd15, 0, 3'd3);
  endtask

  task automatic t_ext_order();
    put(8'h4D); put(8'h66); put(8'h01); put(8'hC0);
    check_dec("R8 ext not adjacent", 1, 0, 2'd1, 4'd0, 0, 4'd0, 0, 3'd4);
  endtask

  task automatic t_bad_opnd();
    put(8'h01); put(8'h80);
    check_err("R9 memory-form operand");
    put(8'h01); put(8'hC3);
    check_dec("R9 recovers", 1, 0, 2'd2, 4'd0, 0, 4'd3, 0, 3'd2);
  endtask

  task automatic t_bad_opc();
    put(8'h90);
    check_err("R10 unknown byte");
    put(8'h66); put(8'h02);
    check_err("R10 unknown opcode after prefix");
    put(8'h01); put(8'hC4);
    check_dec("R10 recovers", 1, 0, 2'd2, 4'd0, 0, 4'd4, 0, 3'd2);
  endtask

  task automatic t_pfx_overflow();
    put(8'h66); put(8'h66); put(8'h66);
    check_err("R11 too many prefixes");
    put(8'h01); put(8'hC6);
    check_dec("R11 recovers", 1, 0, 2'd2, 4'd0, 0, 4'd6, 0, 3'd2);
  endtask

  task automatic t_gaps();
    put(8'h66); gap(2); put(8'h01); gap(1); put(8'hC1);
    check_dec("R12 idle cycles ignored", 1, 0, 2'd1, 4'd0, 0, 4'd1, 0, 3'd3);
  endtask

  task automatic t_hold();
    put(8'h01); put(8'hCA);
    check_dec("R13 base", 1, 0, 2'd2, 4'd1, 0, 4'd2, 0, 3'd2);
    gap(3);
    check_dec("R13 held idle", 0, 0, 2'd2, 4'd1, 0, 4'd2, 0, 3'd2);
    put(8'h66); put(8'h01);
    check_dec("R13 held partial", 0, 0, 2'd2, 4'd1, 0, 4'd2, 0, 3'd2);
    put(8'hC0);
    check_dec("R13 next result", 1, 0, 2'd1, 4'd0, 0, 4'd0, 0, 3'd3);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL R12 watchdog actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset();
    t_plain32();
    t_size16();
    t_size64();
    t_byte_legacy();
    t_byte_ext();
    t_ext_bits();
    t_ext_order();
    t_bad_opnd();
    t_bad_opc();
    t_pfx_overflow();
    t_gaps();
    t_hold();
    gap(2);
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule